// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station Array

This block is the scheduling core of a dynamically scheduled execution back end. Instructions arrive in program order at a dispatch port, each naming an execution class, an opcode, two source registers and an optional destination register. The block places each accepted instruction into a free reservation station of its class. Each source is read from a register status table either as a present value or as the tag of the station that will produce it. When a destination is named, the table entry is then renamed to the new station's tag. Because of this renaming, later writers of a register never wait for earlier readers or writers.

A single result bus brings back one completed result per cycle, as a value plus the producer's tag. Every waiting station operand and every register entry that holds that tag captures the value. A station whose operands are all present requests issue to its class's functional unit, and the lowest-numbered ready station of each class wins. The station stays occupied until its own tag appears on the result bus. Station counts, widths and the register count are parameters. The execution units, memory ordering and commit sit outside the block.

Top module: `rs_sched`

## Requirements
- R1: After reset all stations are free and every register entry holds an empty tag and value zero. With default parameters `disp_ready` is 1 for classes 0, 1 and 2, and no class shows `iss_valid`.
- R2: Tag 0 means "no producer". Class code 0 is the adder class (tags 1-3), code 1 the multiplier class (tags 4-5) and code 2 the load class (tags 6-8). Code 3 is never accepted. `disp_ready` is 1 exactly when the requested class has a free station, and an accepted instruction takes the lowest-numbered free station of its class.
- R3: At dispatch, a source whose register entry has an empty tag is copied into the station as a value. Otherwise the station records the producer tag and waits.
- R4: When the result bus carries the tag a dispatching source would record, in the same cycle, the station takes the bus value directly and starts with that operand present.
- R5: An accepted instruction with `disp_dst_en` set writes its station tag into the destination's register entry, replacing any earlier tag. Stations already dispatched keep the tag or value they captured.
- R6: A result bus transfer makes every occupied station operand and every register entry holding that tag take the value and clear the tag. A register entry renamed in the same cycle keeps its new tag.
- R7: A station is ready when it is occupied, has not yet issued, and both operand tags are empty. Each class presents its lowest-numbered ready station on `iss_*`, and the station is marked issued when `iss_ready` of that class is high.
- R8: A station is freed in the cycle after its own tag appears on the result bus, and can be allocated again from then on.
- R9: With `LOAD_ONE_SRC` set (default), load-class stations ignore source B: its operand is always present and issues as value zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_cls | input | 2 | Execution class of the instruction |
| disp_op | input | OP_W | Opcode carried to the unit |
| disp_src_a | input | REG_W | Source register A |
| disp_src_b | input | REG_W | Source register B |
| disp_dst_en | input | 1 | Instruction writes a register |
| disp_dst | input | REG_W | Destination register |
| disp_ready | output | 1 | A station of the requested class is free |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the producing station |
| cdb_value | input | DATA_W | Result value |
| iss_ready | input | 3 | Per class: unit accepts an instruction |
| iss_valid | output | 3 | Per class: a ready station is presented |
| iss_tag | output | 3 x TAG_W | Per class: tag of presented station |
| iss_op | output | 3 x OP_W | Per class: opcode of presented station |
| iss_vj | output | 3 x DATA_W | Per class: operand A value |
| iss_vk | output | 3 x DATA_W | Per class: operand B value |

## Verification
The hardest situations to reach from the ports are timing coincidences. One is a dispatch that reads a register while that register's producer is on the result bus in the same cycle. Another is a broadcast of an older producer's tag after a younger writer has already renamed the same register. A directed sequence sets up both: it issues a producer, then aligns its broadcast with a dependent dispatch, then stacks two writers of one register with consumers between them and retires them in order. Long random runs then drive broadcasts only with tags of stations the bench knows have issued. This keeps the protocol legal while still mixing dispatch, snoop, rename and release in the same cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
   localparam int NCLS = 3;

   typedef enum logic [1:0] {
      CLS_ADD  = 2'd0,
      CLS_MUL  = 2'd1,
      CLS_LOAD = 2'd2,
      CLS_NONE = 2'd3
   } exec_cls_e;
endpackage

// File: rtl/rs_regstat.sv
module rs_regstat #(
   parameter int NREG   = 8,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16,
   parameter int IDX_W  = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [TAG_W-1:0]  rd_a_q,
   output logic [DATA_W-1:0] rd_a_v,
   output logic [TAG_W-1:0]  rd_b_q,
   output logic [DATA_W-1:0] rd_b_v,
   input  logic              ren_en,
   input  logic [IDX_W-1:0]  ren_idx,
   input  logic [TAG_W-1:0]  ren_tag,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value
);
   if (NREG != (1 << IDX_W)) begin : g_bad_nreg
      $error("rs_regstat: NREG must be a power of two");
   end

   logic [TAG_W-1:0]  q_r [NREG];
   logic [DATA_W-1:0] v_r [NREG];

   // reads see a result broadcast in the same cycle
   always_comb begin
      rd_a_q = q_r[rd_a_idx];
      rd_a_v = v_r[rd_a_idx];
      if (cdb_valid && rd_a_q != '0 && rd_a_q == cdb_tag) begin
         rd_a_q = '0;
         rd_a_v = cdb_value;
      end
      rd_b_q = q_r[rd_b_idx];
      rd_b_v = v_r[rd_b_idx];
      if (cdb_valid && rd_b_q != '0 && rd_b_q == cdb_tag) begin
         rd_b_q = '0;
         rd_b_v = cdb_value;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < NREG; i++) begin
         if (!rst_n) begin
            q_r[i] <= '0;
            v_r[i] <= '0;
         end else begin
            if (cdb_valid && q_r[i] != '0 && q_r[i] == cdb_tag) begin
               q_r[i] <= '0;
               v_r[i] <= cdb_value;
            end
            if (ren_en && ren_idx == IDX_W'(i))
               q_r[i] <= ren_tag;
         end
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_chk
      p_rename_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ren_en && ren_idx == IDX_W'(g) |=> q_r[g] == $past(ren_tag));
      p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
         cdb_valid && q_r[g] != '0 && q_r[g] == cdb_tag &&
         !(ren_en && ren_idx == IDX_W'(g))
         |=> q_r[g] == '0 && v_r[g] == $past(cdb_value));
   end
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
   parameter int DEPTH    = 3,
   parameter int TAG_W    = 4,
   parameter int DATA_W   = 16,
   parameter int OP_W     = 3,
   parameter int TAG_BASE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [OP_W-1:0]   alloc_op,
   input  logic [TAG_W-1:0]  alloc_qj,
   input  logic [DATA_W-1:0] alloc_vj,
   input  logic [TAG_W-1:0]  alloc_qk,
   input  logic [DATA_W-1:0] alloc_vk,
   output logic              has_free,
   output logic [TAG_W-1:0]  free_tag,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_value,
   input  logic              iss_ready,
   output logic              iss_valid,
   output logic [TAG_W-1:0]  iss_tag,
   output logic [OP_W-1:0]   iss_op,
   output logic [DATA_W-1:0] iss_vj,
   output logic [DATA_W-1:0] iss_vk
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 1) begin : g_bad_depth
      $error("rs_bank: DEPTH must be at least one");
   end
   if (TAG_BASE + DEPTH > (1 << TAG_W)) begin : g_bad_tag
      $error("rs_bank: tags do not fit in TAG_W");
   end

   logic [DEPTH-1:0]  busy_r, exec_r, rdy;
   logic [OP_W-1:0]   op_r [DEPTH];
   logic [TAG_W-1:0]  qj_r [DEPTH];
   logic [TAG_W-1:0]  qk_r [DEPTH];
   logic [DATA_W-1:0] vj_r [DEPTH];
   logic [DATA_W-1:0] vk_r [DEPTH];
   logic [IDX_W-1:0]  free_idx, sel_idx;
   logic              iss_fire;

   function automatic logic [TAG_W-1:0] ent_tag(input int i);
      return TAG_W'(TAG_BASE + i);
   endfunction

   // lowest free entry
   always_comb begin
      has_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!busy_r[i]) begin
            has_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
      free_tag = ent_tag(int'(free_idx));
   end

   // lowest ready entry
   always_comb begin
      iss_valid = 1'b0;
      sel_idx   = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         rdy[i] = busy_r[i] && !exec_r[i] && qj_r[i] == '0 && qk_r[i] == '0;
         if (rdy[i]) begin
            iss_valid = 1'b1;
            sel_idx   = IDX_W'(i);
         end
      end
      iss_tag  = ent_tag(int'(sel_idx));
      iss_op   = op_r[sel_idx];
      iss_vj   = vj_r[sel_idx];
      iss_vk   = vk_r[sel_idx];
      iss_fire = iss_valid && iss_ready;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!rst_n) begin
            busy_r[i] <= 1'b0;
            exec_r[i] <= 1'b0;
            op_r[i]   <= '0;
            qj_r[i]   <= '0;
            qk_r[i]   <= '0;
            vj_r[i]   <= '0;
            vk_r[i]   <= '0;
         end else begin
            if (busy_r[i] && cdb_valid && cdb_tag == ent_tag(i)) begin
               busy_r[i] <= 1'b0;
               exec_r[i] <= 1'b0;
            end else if (iss_fire && sel_idx == IDX_W'(i)) begin
               exec_r[i] <= 1'b1;
            end
            if (busy_r[i] && cdb_valid && qj_r[i] != '0 && qj_r[i] == cdb_tag) begin
               qj_r[i] <= '0;
               vj_r[i] <= cdb_value;
            end
            if (busy_r[i] && cdb_valid && qk_r[i] != '0 && qk_r[i] == cdb_tag) begin
               qk_r[i] <= '0;
               vk_r[i] <= cdb_value;
            end
            if (alloc_en && free_idx == IDX_W'(i)) begin
               busy_r[i] <= 1'b1;
               exec_r[i] <= 1'b0;
               op_r[i]   <= alloc_op;
               qj_r[i]   <= alloc_qj;
               vj_r[i]   <= alloc_vj;
               qk_r[i]   <= alloc_qk;
               vk_r[i]   <= alloc_vk;
            end
         end
      end
   end

   p_alloc_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> has_free);

   for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      p_free_on_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
         busy_r[g] && cdb_valid && cdb_tag == TAG_W'(TAG_BASE + g) |=> !busy_r[g]);
      p_issue_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
         iss_fire && sel_idx == IDX_W'(g) &&
         !(cdb_valid && cdb_tag == TAG_W'(TAG_BASE + g)) |=> exec_r[g]);
      p_exec_has_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
         exec_r[g] |-> busy_r[g] && qj_r[g] == '0 && qk_r[g] == '0);
   end
endmodule

// File: rtl/rs_sched.sv
module rs_sched import rs_pkg::*; #(
   parameter int DATA_W       = 16,
   parameter int OP_W         = 3,
   parameter int TAG_W        = 4,
   parameter int NREG         = 8,
   parameter int N_ADD        = 3,
   parameter int N_MUL        = 2,
   parameter int N_LOAD       = 3,
   parameter bit LOAD_ONE_SRC = 1'b1,
   parameter int REG_W        = $clog2(NREG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         disp_valid,
   input  logic [1:0]                   disp_cls,
   input  logic [OP_W-1:0]              disp_op,
   input  logic [REG_W-1:0]             disp_src_a,
   input  logic [REG_W-1:0]             disp_src_b,
   input  logic                         disp_dst_en,
   input  logic [REG_W-1:0]             disp_dst,
   output logic                         disp_ready,
   input  logic                         cdb_valid,
   input  logic [TAG_W-1:0]             cdb_tag,
   input  logic [DATA_W-1:0]            cdb_value,
   input  logic [NCLS-1:0]              iss_ready,
   output logic [NCLS-1:0]              iss_valid,
   output logic [NCLS-1:0][TAG_W-1:0]   iss_tag,
   output logic [NCLS-1:0][OP_W-1:0]    iss_op,
   output logic [NCLS-1:0][DATA_W-1:0]  iss_vj,
   output logic [NCLS-1:0][DATA_W-1:0]  iss_vk
);
   localparam int N_TOTAL = N_ADD + N_MUL + N_LOAD;

   if (N_TOTAL > (1 << TAG_W) - 1) begin : g_bad_tags
      $error("rs_sched: station count exceeds tag space");
   end
   if (N_ADD < 1 || N_MUL < 1 || N_LOAD < 1) begin : g_bad_cnt
      $error("rs_sched: every class needs a station");
   end

   logic [NCLS-1:0]            has_free;
   logic [NCLS-1:0][TAG_W-1:0] free_tag;
   logic [TAG_W-1:0]           alloc_tag;
   logic                       disp_fire;
   logic [TAG_W-1:0]           a_q, b_q;
   logic [DATA_W-1:0]          a_v, b_v;

   always_comb begin
      disp_ready = 1'b0;
      alloc_tag  = '0;
      for (int c = 0; c < NCLS; c++) begin
         if (disp_cls == 2'(c)) begin
            disp_ready = has_free[c];
            alloc_tag  = free_tag[c];
         end
      end
      disp_fire = disp_valid && disp_ready;
   end

   rs_regstat #(
      .NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(REG_W)
   ) i_regstat (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_a_idx  (disp_src_a),
      .rd_b_idx  (disp_src_b),
      .rd_a_q    (a_q),
      .rd_a_v    (a_v),
      .rd_b_q    (b_q),
      .rd_b_v    (b_v),
      .ren_en    (disp_fire && disp_dst_en),
      .ren_idx   (disp_dst),
      .ren_tag   (alloc_tag),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value)
   );

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      localparam int DEP  = (c == 0) ? N_ADD : (c == 1) ? N_MUL : N_LOAD;
      localparam int BASE = 1 + ((c >= 1) ? N_ADD : 0) + ((c >= 2) ? N_MUL : 0);
      logic [TAG_W-1:0]  in_qk;
      logic [DATA_W-1:0] in_vk;

      if (c == int'(CLS_LOAD) && LOAD_ONE_SRC) begin : g_one_src
         assign in_qk = '0;
         assign in_vk = '0;
      end else begin : g_two_src
         assign in_qk = b_q;
         assign in_vk = b_v;
      end

      rs_bank #(
         .DEPTH(DEP), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W), .TAG_BASE(BASE)
      ) i_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_en  (disp_fire && disp_cls == 2'(c)),
         .alloc_op  (disp_op),
         .alloc_qj  (a_q),
         .alloc_vj  (a_v),
         .alloc_qk  (in_qk),
         .alloc_vk  (in_vk),
         .has_free  (has_free[c]),
         .free_tag  (free_tag[c]),
         .cdb_valid (cdb_valid),
         .cdb_tag   (cdb_tag),
         .cdb_value (cdb_value),
         .iss_ready (iss_ready[c]),
         .iss_valid (iss_valid[c]),
         .iss_tag   (iss_tag[c]),
         .iss_op    (iss_op[c]),
         .iss_vj    (iss_vj[c]),
         .iss_vk    (iss_vk[c])
      );
   end

   p_no_cls3_r2: assert property (@(posedge clk) disable iff (!rst_n)
      disp_cls == CLS_NONE |-> !disp_ready);
endmodule

// File: tb/test_rs_sched.sv
`timescale 1ns/100ps
module test_rs_sched;
   localparam int TW = 4, DW = 16, OW = 3, NT = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic disp_valid, disp_dst_en, disp_ready, cdb_valid;
   logic [1:0] disp_cls;
   logic [OW-1:0] disp_op;
   logic [2:0] disp_src_a, disp_src_b, disp_dst;
   logic [TW-1:0] cdb_tag;
   logic [DW-1:0] cdb_value;
   logic [2:0] iss_ready, iss_valid;
   logic [2:0][TW-1:0] iss_tag;
   logic [2:0][OW-1:0] iss_op;
   logic [2:0][DW-1:0] iss_vj, iss_vk;

   always #2.5 clk = ~clk;

   rs_sched i_rs_sched (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_cls(disp_cls),
      .disp_op(disp_op), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
      .disp_dst_en(disp_dst_en), .disp_dst(disp_dst), .disp_ready(disp_ready),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .iss_ready(iss_ready), .iss_valid(iss_valid), .iss_tag(iss_tag),
      .iss_op(iss_op), .iss_vj(iss_vj), .iss_vk(iss_vk)
   );

   int checks = 0, errors = 0;

   // reference model, indexed by tag 1..8 and register 0..7
   logic          m_busy [NT+1];
   logic          m_exec [NT+1];
   logic [OW-1:0] m_op   [NT+1];
   logic [TW-1:0] m_qj   [NT+1];
   logic [TW-1:0] m_qk   [NT+1];
   logic [DW-1:0] m_vj   [NT+1];
   logic [DW-1:0] m_vk   [NT+1];
   logic [TW-1:0] m_rq   [8];
   logic [DW-1:0] m_rv   [8];

   function automatic int cls_of(int t);
      return (t <= 3) ? 0 : (t <= 5) ? 1 : 2;
   endfunction

   function automatic int free_of(int c);
      for (int t = 1; t <= NT; t++)
         if (cls_of(t) == c && !m_busy[t]) return t;
      return 0;
   endfunction

   function automatic int sel_of(int c);
      for (int t = 1; t <= NT; t++)
         if (cls_of(t) == c && m_busy[t] && !m_exec[t] && m_qj[t] == '0 && m_qk[t] == '0)
            return t;
      return 0;
   endfunction

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int t = 0; t <= NT; t++) begin
         m_busy[t] = 0; m_exec[t] = 0; m_op[t] = '0;
         m_qj[t] = '0; m_qk[t] = '0; m_vj[t] = '0; m_vk[t] = '0;
      end
      for (int r = 0; r < 8; r++) begin
         m_rq[r] = '0; m_rv[r] = '0;
      end
   endtask

   task automatic idle();
      disp_valid = 0; disp_cls = 2'd0; disp_op = '0; disp_src_a = '0; disp_src_b = '0;
      disp_dst_en = 0; disp_dst = '0; cdb_valid = 0; cdb_tag = '0; cdb_value = '0;
      iss_ready = '0;
   endtask

   // inputs are set after a falling edge; check, update model, advance one cycle
   task automatic cyc(string lbl);
      int ft, s;
      int sel [3];
      logic exp_rdy, fire;
      logic [TW-1:0] qa, qb;
      logic [DW-1:0] va, vb;
      #1;
      exp_rdy = (disp_cls != 2'd3) && (free_of(int'(disp_cls)) != 0);
      check("R2 R8", "disp_ready", 32'(disp_ready), 32'(exp_rdy));
      for (int c = 0; c < 3; c++) begin
         s = sel_of(c);
         sel[c] = s;
         check("R7", $sformatf("iss_valid[%0d]", c), 32'(iss_valid[c]), 32'(s != 0));
         if (s != 0) begin
            check("R7", "iss_tag", 32'(iss_tag[c]), 32'(s));
            check("R7", "iss_op", 32'(iss_op[c]), 32'(m_op[s]));
            check(lbl, "iss_vj", 32'(iss_vj[c]), 32'(m_vj[s]));
            check((c == 2) ? "R9" : lbl, "iss_vk", 32'(iss_vk[c]), 32'(m_vk[s]));
         end
      end
      fire = disp_valid && exp_rdy;
      ft = fire ? free_of(int'(disp_cls)) : 0;
      qa = m_rq[disp_src_a]; va = m_rv[disp_src_a];
      qb = m_rq[disp_src_b]; vb = m_rv[disp_src_b];
      if (cdb_valid && qa != '0 && qa == cdb_tag) begin qa = '0; va = cdb_value; end
      if (cdb_valid && qb != '0 && qb == cdb_tag) begin qb = '0; vb = cdb_value; end
      if (disp_cls == 2'd2) begin qb = '0; vb = '0; end
      for (int c = 0; c < 3; c++)
         if (sel[c] != 0 && iss_ready[c]) m_exec[sel[c]] = 1;
      if (cdb_valid) begin
         for (int t = 1; t <= NT; t++) begin
            if (m_busy[t] && m_qj[t] != '0 && m_qj[t] == cdb_tag) begin m_qj[t] = '0; m_vj[t] = cdb_value; end
            if (m_busy[t] && m_qk[t] != '0 && m_qk[t] == cdb_tag) begin m_qk[t] = '0; m_vk[t] = cdb_value; end
            if (m_busy[t] && TW'(t) == cdb_tag) begin m_busy[t] = 0; m_exec[t] = 0; end
         end
         for (int r = 0; r < 8; r++)
            if (m_rq[r] != '0 && m_rq[r] == cdb_tag) begin m_rq[r] = '0; m_rv[r] = cdb_value; end
      end
      if (fire) begin
         m_busy[ft] = 1; m_exec[ft] = 0; m_op[ft] = disp_op;
         m_qj[ft] = qa; m_vj[ft] = va; m_qk[ft] = qb; m_vk[ft] = vb;
         if (disp_dst_en) m_rq[disp_dst] = TW'(ft);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 0;
      idle();
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
   endtask

   task automatic disp(logic [1:0] c, logic [2:0] op, logic [2:0] a, logic [2:0] b,
                       logic den, logic [2:0] d);
      disp_valid = 1; disp_cls = c; disp_op = op; disp_src_a = a; disp_src_b = b;
      disp_dst_en = den; disp_dst = d;
   endtask

   task automatic bcast(logic [TW-1:0] t, logic [DW-1:0] v);
      cdb_valid = 1; cdb_tag = t; cdb_value = v;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1234_5678));
      do_reset();

      // R1: reset state, every class free, nothing issuing
      for (int c = 0; c < 3; c++) begin
         idle(); disp_cls = 2'(c); cyc("R1");
      end

      // R2: fill the adder class, then stall; code 3 refused; R7 lowest first
      for (int k = 0; k < 4; k++) begin
         idle(); disp(2'd0, 3'(k + 1), 3'd1, 3'd2, 1'b0, 3'd0); cyc("R3");
      end
      idle(); disp(2'd3, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0); cyc("R2");
      for (int k = 0; k < 3; k++) begin
         idle(); iss_ready = 3'b001; cyc("R7");
      end
      idle(); bcast(4'd2, 16'h0abc); cyc("R8");
      idle(); disp(2'd0, 3'd7, 3'd0, 3'd0, 1'b0, 3'd0); cyc("R8");
      idle(); cyc("R8");

      // R4: same-cycle broadcast captured at dispatch
      do_reset();
      idle(); disp(2'd0, 3'd1, 3'd1, 3'd2, 1'b1, 3'd3); cyc("R3");
      idle(); iss_ready = 3'b001; cyc("R7");
      idle(); disp(2'd1, 3'd2, 3'd3, 3'd3, 1'b1, 3'd5); bcast(4'd1, 16'h0055); cyc("R4");
      idle(); cyc("R4");

      // R5/R6: two writers of r3 with consumers between them
      idle(); disp(2'd0, 3'd3, 3'd3, 3'd0, 1'b1, 3'd3); cyc("R5");
      idle(); disp(2'd1, 3'd4, 3'd3, 3'd0, 1'b1, 3'd6); cyc("R5");
      idle(); disp(2'd0, 3'd5, 3'd0, 3'd0, 1'b1, 3'd3); cyc("R5");
      idle(); disp(2'd2, 3'd6, 3'd3, 3'd3, 1'b0, 3'd0); cyc("R5");
      idle(); iss_ready = 3'b001; cyc("R7");
      idle(); iss_ready = 3'b001; bcast(4'd1, 16'h1111); cyc("R6");
      idle(); bcast(4'd2, 16'h2222); cyc("R6");
      idle(); cyc("R6");
      idle(); iss_ready = 3'b110; cyc("R6");
      idle(); disp(2'd2, 3'd1, 3'd3, 3'd3, 1'b0, 3'd0); cyc("R9");
      idle(); cyc("R9");

      // constrained random traffic
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         int t;
         idle();
         if ($urandom_range(0, 2) != 0)
            disp(2'($urandom_range(0, 3)), 3'($urandom), 3'($urandom), 3'($urandom),
                 1'($urandom), 3'($urandom));
         t = $urandom_range(1, NT);
         if (m_exec[t] && $urandom_range(0, 3) != 0) bcast(TW'(t), 16'($urandom));
         iss_ready = 3'($urandom);
         cyc("R3 R5 R6");
      end

      summary();
      $finish;
   end
endmodule